// File: doc/BRIEF.md
# Adaptive Write-Cancelling Bank Scheduler

This block sits in front of a single memory bank whose writes take far longer than its reads. Reads and writes come in on separate valid/ready request ports and wait in two queues, one per direction. The scheduler starts one operation at a time on the bank and times it with its own cycle counter, using fixed read and write service times. A read that finishes on the bank comes back on a tagged response port.

Reads normally go ahead of writes. When the write queue fills to a set fraction of its depth, the scheduler switches to a forced mode and drains writes oldest-first. A write that is already running can be abandoned so that a waiting read can use the bank. Whether that happens depends on two things: how much of the write has elapsed, and an allowance that shrinks as the write queue fills. A write started in forced mode always runs to completion. An abandoned write keeps its place in the queue and starts again from the beginning.

An abandoned line holds unknown contents, so every incoming read is first compared against the queued writes. On a match, the read is answered with the data of the newest matching write and never reaches the bank. Because of this, responses can come back in a different order from the requests, and the tag tells them apart.

Request ports follow valid/ready rules. A request moves on a cycle where both valid and ready are high. A sender must hold valid and its payload steady until that happens. Ready does not depend on valid.

The response port has no ready and cannot be stalled. It presents each response for exactly one cycle. To keep two responses from landing in the same cycle, the read port withholds ready in the last service cycle of a bank read.

Top module: `wcs_top`

## Requirements
- R1: While reset is held and in the first cycle after it, rd_ready and wr_ready are high, and bank_cmd_valid, bank_abort and rsp_valid are low.
- R2: rd_ready is low when the read queue holds DEPTH entries, and also in the last service cycle of a bank read. wr_ready is low when the write queue holds DEPTH entries.
- R3: At most one operation is in service. bank_cmd_valid is asserted only in a cycle where the bank is idle, and the cycle after a service ends (finish or abort) is always idle.
- R4: While the write queue holds fewer than the forced level of entries, an idle bank with a queued read issues the oldest queued read (bank_cmd_write low). It issues the oldest write only when no read is queued.
- R5: The forced level is reached when occupancy×100 ≥ DEPTH×FORCE_PCT. At or above it, an idle bank issues the oldest queued write (bank_cmd_write high) ahead of any queued read.
- R6: A read issued in cycle t samples bank_rdata in cycle t+RD_LAT. Its response, carrying that data, is valid in cycle t+RD_LAT+1.
- R7: A write issued in cycle t that is not abandoned occupies the bank through cycle t+WR_LAT. It leaves the write queue at the end of that cycle, and its data is driven on bank_cmd_wdata in cycle t.
- R8: Count the service cycles of a write starting at 1 in the cycle after its command. A write that was not started in forced mode is abandoned (bank_abort high for one cycle) in the first cycle where the read queue is non-empty and count×100 < WR_LAT×threshold.
- R9: threshold = 100 − STEP×occupancy, floored at 0, where occupancy is the current number of write-queue entries and STEP defaults to 4.
- R10: A write issued while the forced level is reached is never abandoned.
- R11: An abandoned write stays at its queue position. When it is next selected, it is issued again with its full WR_LAT service time.
- R12: A read accepted while its address equals that of an entry already in the write queue does not enter the read queue. In the next cycle it gets a response carrying the data of the newest such entry. A write accepted in the same cycle is not seen by this match.
- R13: Every response carries the tag given with its read, whether the read was served by the bank or by forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted this cycle when high with rd_valid |
| rd_addr | input | ADDR_W | Read address |
| rd_tag | input | TAG_W | Read identifier returned on the response |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted this cycle when high with wr_valid |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| bank_cmd_valid | output | 1 | One-cycle start of a bank operation |
| bank_cmd_write | output | 1 | Started operation is a write |
| bank_cmd_addr | output | ADDR_W | Address of the started operation |
| bank_cmd_wdata | output | DATA_W | Data of the started write |
| bank_abort | output | 1 | One-cycle abandon of the write in service |
| bank_rdata | input | DATA_W | Bank read data, sampled in the last read service cycle |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_tag | output | TAG_W | Tag of the answered read |
| rsp_data | output | DATA_W | Read data |

## Verification
The bench builds the block with an 8-entry queue, a 4-cycle read, a 20-cycle write, STEP 12 and a 16-word address space. This makes forced mode start at seven queued writes, and it sweeps the abandon allowance from 88% down to 16% within a few dozen cycles. With only sixteen addresses, forwarding hits are frequent. The short write time lets reads land at early, middle and late points of a write, so both sides of the abandon rule are exercised. Phases of write floods drive the queue into forced mode and out again. Phases dominated by reads fill the read queue and hold back its ready.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  // Service state of the bank as seen by the scheduler.
  typedef enum logic [1:0] {
    SVC_IDLE  = 2'd0,
    SVC_READ  = 2'd1,
    SVC_WRITE = 2'd2
  } svc_e;

  // Abandon allowance in percent, floored at zero.
  function automatic logic [31:0] wcs_allowance(input logic [31:0] occ, input logic [31:0] step);
    logic [31:0] load;
    load = occ * step;
    return (load >= 32'd100) ? 32'd0 : (32'd100 - load);
  endfunction

endpackage

// File: rtl/wcs_fifo.sv
module wcs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fill;

  assign full  = (fill == CW'(DEPTH));
  assign empty = (fill == '0);
  assign dout  = mem_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) begin
        mem_q[wr_ptr] <= din;
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      end
      if (pop) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  // R2: the producer must never push into a full queue
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R4: a read is only issued from a non-empty queue
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/wcs_wrq.sv
module wcs_wrq #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  input  logic [AW-1:0] look_addr,
  output logic          look_hit,
  output logic [DW-1:0] look_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] age [DEPTH];
  logic [DEPTH-1:0] match;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign head_addr = addr_q[head];
  assign head_data = data_q[head];

  // Per-slot age relative to the head and address comparison.
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    localparam logic [PW-1:0] SIDX = PW'(s);
    always_comb begin
      if (SIDX >= head) age[s] = CW'(SIDX - head);
      else              age[s] = CW'(DEPTH) - CW'(head - SIDX);
      match[s] = (age[s] < count) && (addr_q[s] == look_addr);
    end
  end

  // Newest matching entry wins.
  always_comb begin
    logic [CW-1:0] best;
    look_hit  = 1'b0;
    look_data = '0;
    best      = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (match[s] && (!look_hit || age[s] > best)) begin
        look_hit  = 1'b1;
        look_data = data_q[s];
        best      = age[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        addr_q[tail] <= push_addr;
        data_q[tail] <= push_data;
        tail <= (tail == PW'(DEPTH - 1)) ? '0 : tail + PW'(1);
      end
      if (pop) head <= (head == PW'(DEPTH - 1)) ? '0 : head + PW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R2: writes are never accepted into a full queue
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R7: only a queued write can retire
  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/wcs_engine.sv
module wcs_engine import wcs_pkg::*; #(
  parameter int DEPTH     = 32,
  parameter int RD_LAT    = 1000,
  parameter int WR_LAT    = 8000,
  parameter int STEP      = 4,
  parameter int FORCE_PCT = 80,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rdq_empty,
  input  logic          wq_empty,
  input  logic [CW-1:0] wq_count,
  output logic          issue_rd,
  output logic          issue_wr,
  output logic          abort,
  output logic          rd_fin,
  output logic          wr_fin
);
  localparam int MAXL = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int LW   = $clog2(MAXL + 1);
  localparam int PW   = LW + $clog2(WR_LAT + 1) + 8;

  svc_e          state;
  logic [LW-1:0] cnt;
  logic          forced;
  logic          idle, forced_now, at_end;
  logic [31:0]   allow;
  logic [PW-1:0] done_pct, allow_pct;

  assign idle       = (state == SVC_IDLE);
  assign forced_now = (32'(wq_count) * 32'd100) >= 32'(DEPTH * FORCE_PCT);
  assign allow      = wcs_allowance(32'(wq_count), 32'(STEP));
  assign done_pct   = PW'(cnt) * PW'(100);
  assign allow_pct  = PW'(WR_LAT) * PW'(allow);
  assign at_end     = (state == SVC_WRITE) ? (cnt == LW'(WR_LAT)) : (cnt == LW'(RD_LAT));

  always_comb begin
    issue_wr = idle && !wq_empty && (forced_now || rdq_empty);
    issue_rd = idle && !rdq_empty && !(forced_now && !wq_empty);
    rd_fin   = (state == SVC_READ) && at_end;
    wr_fin   = (state == SVC_WRITE) && at_end;
    abort    = (state == SVC_WRITE) && !forced && !rdq_empty && (done_pct < allow_pct);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SVC_IDLE;
      cnt    <= '0;
      forced <= 1'b0;
    end else begin
      unique case (state)
        SVC_IDLE: begin
          if (issue_rd) begin
            state <= SVC_READ;
            cnt   <= LW'(1);
          end else if (issue_wr) begin
            state  <= SVC_WRITE;
            cnt    <= LW'(1);
            forced <= forced_now;
          end
        end
        default: begin
          if (rd_fin || wr_fin || abort) begin
            state <= SVC_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + LW'(1);
          end
        end
      endcase
    end
  end

  // R8: an abandoned write frees the bank on the next cycle
  assert_abort_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state == SVC_IDLE));
  // R7: service time advances one step per cycle until the end or an abandon
  assert_progress_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !rd_fin && !wr_fin && !abort) |=> (cnt == $past(cnt) + LW'(1)));
  // R10: a forced write keeps the bank until its end
  assert_forced_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SVC_WRITE && forced && !wr_fin) |=> (state == SVC_WRITE));

endmodule

// File: rtl/wcs_top.sv
module wcs_top #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int TAG_W     = 6,
  parameter int DEPTH     = 32,
  parameter int RD_LAT    = 1000,
  parameter int WR_LAT    = 8000,
  parameter int STEP      = 4,
  parameter int FORCE_PCT = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              bank_cmd_valid,
  output logic              bank_cmd_write,
  output logic [ADDR_W-1:0] bank_cmd_addr,
  output logic [DATA_W-1:0] bank_cmd_wdata,
  output logic              bank_abort,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int RW = ADDR_W + TAG_W;

  logic              rdq_full, rdq_empty, rdq_push;
  logic [RW-1:0]     rdq_head;
  logic [ADDR_W-1:0] rdq_head_addr;
  logic [TAG_W-1:0]  rdq_head_tag;
  logic              wq_full, wq_empty, wq_push, wq_hit;
  logic [CW-1:0]     wq_count;
  logic [ADDR_W-1:0] wq_head_addr;
  logic [DATA_W-1:0] wq_head_data, wq_hit_data;
  logic              issue_rd, issue_wr, abort, rd_fin, wr_fin;
  logic              rd_fire, fwd;
  logic [TAG_W-1:0]  cur_tag;

  assign rd_ready = !rdq_full && !rd_fin;
  assign wr_ready = !wq_full;
  assign rd_fire  = rd_valid && rd_ready;
  assign fwd      = rd_fire && wq_hit;
  assign rdq_push = rd_fire && !wq_hit;
  assign wq_push  = wr_valid && wr_ready;
  assign {rdq_head_addr, rdq_head_tag} = rdq_head;

  wcs_fifo #(.W(RW), .DEPTH(DEPTH)) u_rdq (
    .clk(clk), .rst_n(rst_n),
    .push(rdq_push), .din({rd_addr, rd_tag}),
    .pop(issue_rd), .dout(rdq_head),
    .full(rdq_full), .empty(rdq_empty)
  );

  wcs_wrq #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(DEPTH)) u_wrq (
    .clk(clk), .rst_n(rst_n),
    .push(wq_push), .push_addr(wr_addr), .push_data(wr_data),
    .pop(wr_fin), .head_addr(wq_head_addr), .head_data(wq_head_data),
    .count(wq_count), .full(wq_full), .empty(wq_empty),
    .look_addr(rd_addr), .look_hit(wq_hit), .look_data(wq_hit_data)
  );

  wcs_engine #(
    .DEPTH(DEPTH), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT),
    .STEP(STEP), .FORCE_PCT(FORCE_PCT)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .rdq_empty(rdq_empty), .wq_empty(wq_empty), .wq_count(wq_count),
    .issue_rd(issue_rd), .issue_wr(issue_wr), .abort(abort),
    .rd_fin(rd_fin), .wr_fin(wr_fin)
  );

  assign bank_cmd_valid = issue_rd || issue_wr;
  assign bank_cmd_write = issue_wr;
  assign bank_cmd_addr  = issue_wr ? wq_head_addr : rdq_head_addr;
  assign bank_cmd_wdata = wq_head_data;
  assign bank_abort     = abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_tag   <= '0;
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_data  <= '0;
    end else begin
      if (issue_rd) cur_tag <= rdq_head_tag;
      rsp_valid <= rd_fin || fwd;
      if (rd_fin) begin
        rsp_tag  <= cur_tag;
        rsp_data <= bank_rdata;
      end else if (fwd) begin
        rsp_tag  <= rd_tag;
        rsp_data <= wq_hit_data;
      end
    end
  end

  // R6: a response only follows a bank read end or a forwarded read
  assert_rsp_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_fin || fwd));
  // R3: every command is followed by a cycle in service
  assert_cmd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_cmd_valid |=> !bank_cmd_valid);
  // R11: abandoning leaves the write queue head in place
  assert_abort_keeps_head_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bank_abort |=> $stable(wq_head_addr) && $stable(wq_head_data));
  // R7: a finished write leaves the queue
  assert_wr_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fin |=> ((CW + 1)'(wq_count) + (CW + 1)'(1) == (CW + 1)'($past(wq_count)) + (CW + 1)'($past(wq_push))));

endmodule

// File: tb/wcs_top_test.sv
module wcs_top_test;
  localparam int AW = 4, DW = 16, TW = 4, D = 8;
  localparam int RL = 4, WL = 20, ST = 12, FP = 80;
  localparam int NCYC = 3200;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          rd_valid, rd_ready, wr_valid, wr_ready;
  logic [AW-1:0] rd_addr, wr_addr, bank_cmd_addr;
  logic [TW-1:0] rd_tag, rsp_tag;
  logic [DW-1:0] wr_data, bank_cmd_wdata, bank_rdata, rsp_data;
  logic          bank_cmd_valid, bank_cmd_write, bank_abort, rsp_valid;

  // Bench bank storage
  logic [DW-1:0] bmem [16];
  logic [AW-1:0] m_rd_addr;
  assign bank_rdata = bmem[m_rd_addr];

  wcs_top #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .DEPTH(D), .RD_LAT(RL),
            .WR_LAT(WL), .STEP(ST), .FORCE_PCT(FP)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_tag(rd_tag),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank_cmd_valid(bank_cmd_valid), .bank_cmd_write(bank_cmd_write),
    .bank_cmd_addr(bank_cmd_addr), .bank_cmd_wdata(bank_cmd_wdata),
    .bank_abort(bank_abort), .bank_rdata(bank_rdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // Reference model state
  logic [AW-1:0] rq_a[$];
  logic [TW-1:0] rq_t[$];
  logic [AW-1:0] wq_a[$];
  logic [DW-1:0] wq_d[$];
  bit m_busy, m_wr, m_forced;
  int m_cnt;
  logic [TW-1:0] m_tag;
  bit m_rv;
  logic [TW-1:0] m_rt;
  logic [DW-1:0] m_rd;
  // Per-cycle expectations
  bit e_rrdy, e_wrdy, e_ir, e_iw, e_ab, e_rfin, e_wfin, e_fnow;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic eval_model();
    int occ, allow;
    occ    = wq_a.size();
    e_fnow = (occ * 100) >= (D * FP);                       // R5 forced level
    allow  = (ST * occ >= 100) ? 0 : 100 - ST * occ;         // R9 allowance
    e_rfin = m_busy && !m_wr && m_cnt == RL;
    e_wfin = m_busy && m_wr && m_cnt == WL;
    e_rrdy = (rq_a.size() < D) && !e_rfin;                   // R2
    e_wrdy = occ < D;
    e_iw   = !m_busy && occ > 0 && (e_fnow || rq_a.size() == 0);
    e_ir   = !m_busy && rq_a.size() > 0 && !(e_fnow && occ > 0);
    e_ab   = m_busy && m_wr && !m_forced && rq_a.size() > 0 && (m_cnt * 100 < WL * allow); // R8, R10
  endtask

  task automatic compare_all(input bit first);
    string q;
    eval_model();
    q = first ? "R1" : "R2";
    chk(q, "rd_ready", 32'(rd_ready), 32'(e_rrdy));
    chk(q, "wr_ready", 32'(wr_ready), 32'(e_wrdy));
    chk(first ? "R1" : "R3 R4 R5 R11", "bank_cmd_valid", 32'(bank_cmd_valid), 32'(e_ir || e_iw));
    if (e_ir || e_iw) begin
      chk("R5", "bank_cmd_write", 32'(bank_cmd_write), 32'(e_iw));
      chk("R4", "bank_cmd_addr", 32'(bank_cmd_addr), e_iw ? 32'(wq_a[0]) : 32'(rq_a[0]));
      if (e_iw) chk("R7", "bank_cmd_wdata", 32'(bank_cmd_wdata), 32'(wq_d[0]));
    end
    chk(first ? "R1" : "R8 R9 R10", "bank_abort", 32'(bank_abort), 32'(e_ab));
    chk(first ? "R1" : "R6", "rsp_valid", 32'(rsp_valid), 32'(m_rv));
    if (m_rv) begin
      chk("R13", "rsp_tag", 32'(rsp_tag), 32'(m_rt));
      chk("R6 R12", "rsp_data", 32'(rsp_data), 32'(m_rd));
    end
  endtask

  task automatic advance(input bit rv, input logic [AW-1:0] ra, input logic [TW-1:0] rt,
                         input bit wv, input logic [AW-1:0] wa, input logic [DW-1:0] wd);
    bit hit;
    logic [DW-1:0] hd;
    hit = 0; hd = '0;
    foreach (wq_a[i]) if (wq_a[i] == ra) begin hit = 1; hd = wq_d[i]; end  // R12 newest wins
    m_rv = 0;
    if (m_busy) begin
      if (e_rfin) begin
        m_rv = 1; m_rt = m_tag; m_rd = bmem[m_rd_addr]; m_busy = 0;
      end else if (e_wfin) begin
        bmem[wq_a[0]] = wq_d[0];
        void'(wq_a.pop_front()); void'(wq_d.pop_front()); m_busy = 0;
      end else if (e_ab) begin
        m_busy = 0;                                           // R11: entry stays queued
      end else m_cnt++;
    end else if (e_ir) begin
      m_busy = 1; m_wr = 0; m_cnt = 1;
      m_rd_addr = rq_a.pop_front(); m_tag = rq_t.pop_front();
    end else if (e_iw) begin
      m_busy = 1; m_wr = 1; m_cnt = 1; m_forced = e_fnow;
    end
    if (rv && e_rrdy) begin
      if (hit) begin m_rv = 1; m_rt = rt; m_rd = hd; end
      else begin rq_a.push_back(ra); rq_t.push_back(rt); end
    end
    if (wv && e_wrdy) begin wq_a.push_back(wa); wq_d.push_back(wd); end
  endtask

  initial begin
    logic [TW-1:0] tag_ctr;
    int prd, pwr;
    rst_n = 0; rd_valid = 0; wr_valid = 0;
    rd_addr = '0; rd_tag = '0; wr_addr = '0; wr_data = '0;
    for (int i = 0; i < 16; i++) bmem[i] = DW'(i * 977 + 5);
    m_busy = 0; m_wr = 0; m_forced = 0; m_cnt = 0; m_tag = '0; m_rd_addr = '0;
    m_rv = 0; m_rt = '0; m_rd = '0; tag_ctr = '0;
    repeat (4) @(negedge clk);
    eval_model();
    chk("R1", "rd_ready in reset", 32'(rd_ready), 32'(1));
    chk("R1", "wr_ready in reset", 32'(wr_ready), 32'(1));
    rst_n = 1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      compare_all(cyc == 0);
      // Traffic phases: sparse, write flood (forced mode), read heavy, drain
      if (cyc < 700)       begin prd = 20; pwr = 8;  end
      else if (cyc < 1500) begin prd = 12; pwr = 55; end
      else if (cyc < 2600) begin prd = 60; pwr = 20; end
      else                 begin prd = 0;  pwr = 0;  end
      if (!(rd_valid && !e_rrdy)) begin
        rd_valid = ($urandom % 100) < prd;
        rd_addr  = AW'($urandom);
        rd_tag   = tag_ctr;
        if (rd_valid) tag_ctr = tag_ctr + 1'b1;
      end
      if (!(wr_valid && !e_wrdy)) begin
        wr_valid = ($urandom % 100) < pwr;
        wr_addr  = AW'($urandom);
        wr_data  = DW'($urandom);
      end
      advance(rd_valid, rd_addr, rd_tag, wr_valid, wr_addr, wr_data);
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule